// File: doc/BRIEF.md
# DSP Status and Condition Register

This block holds the status word of a DSP datapath. When an unconditional arithmetic or logic operation completes, it records four result flags: greater-than, zero, negative and overflow. It also keeps a three-bit condition-select field that software programs. The selected condition is copied into a single condition bit. Conditional DSP instructions use this bit to decide whether their register writeback happens. The condition bit has no effect on CPU-side actions.

The datapath presents the operation result, its carry/borrow and overflow indications, and an instruction-class code, all qualified by a valid strobe. A system-register port writes the whole word and always reads it back. The upper 24 bits always read as zero. The block does not compute any arithmetic. It only turns the datapath's indications into flags and registers them.

Top module: `dsp_status_reg`

## Requirements
- R1: After a synchronous active-low reset the read value is all zero, and bits 31..8 of the read value are zero at all times.
- R2: The register takes its new value on the clock edge that samples a valid ALU-class operation (class code 3'd1). The fields are then: bit 7 GT = (N xor V)==0 and Z==0; bit 6 Z = result equals zero; bit 5 N = result MSB; bit 4 V = the overflow input.
- R3: A flag update leaves the condition-select field (bits 3..1) unchanged. Only a system write alters it.
- R4: On a flag update, bit 0 (the condition bit, also driven on `cond_bit`) takes the condition chosen by the select field. The choices are: 000 carry input; 001 N; 010 Z; 011 V; 100 signed greater-than (GT as in R2); 101 signed greater-or-equal ((N xor V)==0). For the reserved codes 110 and 111 the bit is 0.
- R5: A valid operation of any other class leaves the whole register unchanged. This covers 3'd0 CPU-side, 3'd2 signed multiply, 3'd3 data move, 3'd4 conditional operation and codes 5..7.
- R6: A system write stores `sr_wdata[7:0]` (condition-select codes 110 and 111 included) and shows it on the next cycle. Written bits 31..8 are dropped.
- R7: When a system write and a valid operation fall in the same cycle, the written value is stored and the operation is ignored.
- R8: With neither a valid operation nor a system write, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation completes this cycle |
| op_class | input | 3 | Instruction-class code of that operation |
| op_result | input | RES_W | Result of the operation (guard bits included) |
| op_carry | input | 1 | Carry/borrow out of the operation |
| op_ovf | input | 1 | Overflow indication of the operation |
| sr_wr | input | 1 | System-register write strobe |
| sr_wdata | input | 32 | System-register write data |
| sr_rdata | output | 32 | Current register value |
| cond_bit | output | 1 | Condition bit used to gate conditional writeback |

## Verification
The assertions assume that `op_class` and the data inputs are meaningful only while `op_valid` is high. They also assume that a system write may coincide with an operation, and that the write then wins. The stimulus drives every input on the falling edge and keeps it for exactly one cycle, so each sampled edge sees one clean request. The sweep uses an 8-bit result width and covers every select code (including the two reserved ones), every result value and every carry/overflow pair. It derives the expected word arithmetically.

// File: rtl/dsr_pkg.sv
// Package: shared codes for the DSP status register.
// Assumes: class codes are fixed by the instruction decoder.
package dsr_pkg;
    localparam int SR_W = 32;
    localparam int LIVE_W = 8;

    typedef enum logic [2:0] {
        CLS_CPU  = 3'd0,
        CLS_ALU  = 3'd1,
        CLS_MUL  = 3'd2,
        CLS_MOVE = 3'd3,
        CLS_COND = 3'd4
    } op_class_e;

    typedef enum logic [2:0] {
        SEL_CARRY = 3'd0,
        SEL_NEG   = 3'd1,
        SEL_ZERO  = 3'd2,
        SEL_OVF   = 3'd3,
        SEL_SGT   = 3'd4,
        SEL_SGE   = 3'd5
    } cond_sel_e;

    typedef struct packed {
        logic gt;
        logic z;
        logic n;
        logic v;
    } flags_t;
endpackage

// File: rtl/dsr_flag_gen.sv
// Module: derives the four result flags from the datapath outputs.
// Assumes: the result is two's complement and its MSB is the sign.
module dsr_flag_gen #(
    parameter int RES_W = 40
) (
    input  logic [RES_W-1:0] result,
    input  logic             ovf,
    output dsr_pkg::flags_t  flags
);
    localparam int MSB = RES_W - 1;

    // Combinational flag derivation.
    always_comb begin
        flags.z  = (result == '0);
        flags.n  = result[MSB];
        flags.v  = ovf;
        flags.gt = ~(result[MSB] ^ ovf) & ~(result == '0);
    end
endmodule

// File: rtl/dsr_cond_sel.sv
// Module: picks the condition bit from the flags using the select field.
// Assumes: reserved select codes produce a false condition.
module dsr_cond_sel (
    input  logic [2:0]      sel,
    input  dsr_pkg::flags_t flags,
    input  logic            carry,
    output logic            cond
);
    import dsr_pkg::*;

    logic ge;

    // Selection of the condition driving the condition bit.
    always_comb begin
        ge = ~(flags.n ^ flags.v);
        case (sel)
            SEL_CARRY: cond = carry;
            SEL_NEG:   cond = flags.n;
            SEL_ZERO:  cond = flags.z;
            SEL_OVF:   cond = flags.v;
            SEL_SGT:   cond = ge & ~flags.z;
            SEL_SGE:   cond = ge;
            default:   cond = 1'b0;
        endcase
    end
endmodule

// File: rtl/dsr_update_ctl.sv
// Module: decides per cycle whether the register is loaded, updated or held.
// Assumes: a system write outranks any operation in the same cycle.
module dsr_update_ctl (
    input  logic       op_valid,
    input  logic [2:0] op_class,
    input  logic       sr_wr,
    output logic       do_load,
    output logic       do_flags
);
    import dsr_pkg::*;

    // Priority decode of load versus flag update.
    always_comb begin
        do_load  = sr_wr;
        do_flags = ~sr_wr & op_valid & (op_class == CLS_ALU);
    end
endmodule

// File: rtl/dsp_status_reg.sv
// Module: DSP status/condition register top.
// Assumes: op_* inputs are meaningful only while op_valid is high.
module dsp_status_reg #(
    parameter int RES_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [2:0]       op_class,
    input  logic [RES_W-1:0] op_result,
    input  logic             op_carry,
    input  logic             op_ovf,
    input  logic             sr_wr,
    input  logic [31:0]      sr_wdata,
    output logic [31:0]      sr_rdata,
    output logic             cond_bit
);
    import dsr_pkg::*;

    localparam int PAD_W = SR_W - LIVE_W;

    flags_t     flags_now;
    logic       cond_now;
    logic       do_load;
    logic       do_flags;
    flags_t     flags_q;
    logic [2:0] sel_q;
    logic       cond_q;

    dsr_flag_gen #(.RES_W(RES_W)) u_flags (
        .result (op_result),
        .ovf    (op_ovf),
        .flags  (flags_now)
    );

    dsr_cond_sel u_sel (
        .sel   (sel_q),
        .flags (flags_now),
        .carry (op_carry),
        .cond  (cond_now)
    );

    dsr_update_ctl u_ctl (
        .op_valid (op_valid),
        .op_class (op_class),
        .sr_wr    (sr_wr),
        .do_load  (do_load),
        .do_flags (do_flags)
    );

    // State register: reset, system load, or flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            sel_q   <= '0;
            cond_q  <= 1'b0;
        end else if (do_load) begin
            flags_q <= flags_t'(sr_wdata[7:4]);
            sel_q   <= sr_wdata[3:1];
            cond_q  <= sr_wdata[0];
        end else if (do_flags) begin
            flags_q <= flags_now;
            cond_q  <= cond_now;
        end
    end

    // Read-back assembly with zeroed upper bits.
    always_comb begin
        sr_rdata = {{PAD_W{1'b0}}, flags_q, sel_q, cond_q};
        cond_bit = cond_q;
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sr_rdata[31:8] == '0); // R1
    AST_SEL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !sr_wr) |=> $stable(sr_rdata[3:1])); // R3
    AST_RSVD_SEL_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !sr_wr && op_class == 3'd1 && sr_rdata[3:2] == 2'b11) |=> !cond_bit); // R4
    AST_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !sr_wr && op_class != 3'd1) |=> $stable(sr_rdata)); // R5
    AST_SYS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr |=> sr_rdata[7:0] == $past(sr_wdata[7:0])); // R6
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr && op_valid) |=> sr_rdata[0] == $past(sr_wdata[0])); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !sr_wr) |=> $stable(sr_rdata)); // R8
endmodule

// File: tb/sim_dsp_status_reg.sv
// Bench: exhaustive sweep over an 8-bit result for every select code.
module sim_dsp_status_reg;
    localparam int RW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [2:0]    op_class = 3'd0;
    logic [RW-1:0] op_result = '0;
    logic          op_carry = 1'b0;
    logic          op_ovf = 1'b0;
    logic          sr_wr = 1'b0;
    logic [31:0]   sr_wdata = '0;
    logic [31:0]   sr_rdata;
    logic          cond_bit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dsp_status_reg #(.RES_W(RW)) u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
        .op_result(op_result), .op_carry(op_carry), .op_ovf(op_ovf),
        .sr_wr(sr_wr), .sr_wdata(sr_wdata), .sr_rdata(sr_rdata), .cond_bit(cond_bit)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a falling edge: one-cycle system write.
    task automatic sys_write(input logic [31:0] d);
        sr_wr = 1'b1; sr_wdata = d;
        @(negedge clk);
        sr_wr = 1'b0;
    endtask

    // Called at a falling edge: one-cycle operation.
    task automatic do_op(input logic [2:0] cls, input logic [RW-1:0] r, input logic c, input logic v);
        op_valid = 1'b1; op_class = cls; op_result = r; op_carry = c; op_ovf = v;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    function automatic logic [31:0] expect_word(input logic [2:0] cs, input logic [RW-1:0] r,
                                                input logic c, input logic v);
        logic z, n, gt, ge, dc;
        z = (r == 0);
        n = r[RW-1];
        ge = (n == v);
        gt = ge && !z;
        case (cs)
            3'd0: dc = c;
            3'd1: dc = n;
            3'd2: dc = z;
            3'd3: dc = v;
            3'd4: dc = gt;
            3'd5: dc = ge;
            default: dc = 1'b0;
        endcase
        return {24'h0, gt, z, n, v, cs, dc};
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] hold;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset", sr_rdata, 32'h0);

        // R6: write with all ones, upper bits dropped
        sys_write(32'hFFFF_FFFF);
        check("R6 write", sr_rdata, 32'h0000_00FF);
        check("R1 reserved", {24'h0, sr_rdata[31:8]}, 32'h0);

        // R2 R3 R4: full sweep
        for (int cs = 0; cs < 8; cs++) begin
            sys_write({28'h0, cs[2:0], 1'b0});
            for (int r = 0; r < (1 << RW); r++) begin
                for (int cv = 0; cv < 4; cv++) begin
                    do_op(3'd1, r[RW-1:0], cv[1], cv[0]);
                    check("R2/R3/R4 update", sr_rdata,
                          expect_word(cs[2:0], r[RW-1:0], cv[1], cv[0]));
                    check("R4 cond_bit", {31'h0, cond_bit},
                          {31'h0, expect_word(cs[2:0], r[RW-1:0], cv[1], cv[0])}[31:0] & 32'h1);
                end
            end
        end

        // R5: other classes leave the word unchanged
        sys_write(32'h0000_00A5);
        for (int k = 0; k < 8; k++) begin
            if (k != 1) begin
                do_op(k[2:0], 8'h00, 1'b1, 1'b1);
                check("R5 no update", sr_rdata, 32'h0000_00A5);
                do_op(k[2:0], 8'h80, 1'b0, 1'b0);
                check("R5 no update", sr_rdata, 32'h0000_00A5);
            end
        end

        // R7: write and operation in the same cycle
        op_valid = 1'b1; op_class = 3'd1; op_result = 8'h00; op_carry = 1'b1; op_ovf = 1'b1;
        sr_wr = 1'b1; sr_wdata = 32'h0000_001C;
        @(negedge clk);
        op_valid = 1'b0; sr_wr = 1'b0;
        check("R7 write wins", sr_rdata, 32'h0000_001C);

        // R6: reserved select accepted by write, then forces condition 0 (R4)
        sys_write(32'h0000_000F);
        check("R6 reserved sel stored", sr_rdata, 32'h0000_000F);
        do_op(3'd1, 8'h00, 1'b1, 1'b0);
        check("R4 reserved sel", sr_rdata, 32'h0000_004E);

        // R8: idle holds
        hold = sr_rdata;
        op_result = 8'hFF; op_ovf = 1'b1; op_class = 3'd1;
        repeat (4) @(negedge clk);
        check("R8 idle hold", sr_rdata, hold);

        // R1: reset clears again
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset again", sr_rdata, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule